// File: doc/BRIEF.md
# Termination Resistor Calibration Sequencer

This block runs the on-chip termination resistor calibration of a USB PHY. The PHY's internal control bits are reached through a separate test-port master, which carries out one register access per request. A single `start` pulse makes the sequencer walk a fixed script. It first drops the three calibration control bits. It then turns the calibration engine on, waits a programmable settling time and triggers the measurement. After that it polls the completion bit. Once the bit is set, it reads back the 4-bit measured code, copies it into the manual trim field and hands control back to the software trim value.

Every script step is one request on the test-port side, held until the master acknowledges it. The settling wait is a cycle counter derived from the clock frequency. Polling is bounded by a maximum number of attempts. If the completion bit never rises, the sequencer skips the code read and the trim write, still runs the release steps, and reports an error together with `done`. The measured code is shown on `result` when `done` pulses and stays there until the next start.

Top module: `term_cal_seq`

## Requirements
- R1: After reset, `tp_req`, `done` and `err` are low and `result` is 0.
- R2: A `start` pulse while idle begins the script. The first three requests are single-bit writes of 0 to addresses 0x43, 0x41 and 0x40, in that order.
- R3: Next comes a single-bit write of 1 to 0x40. Then `tp_req` stays low for exactly WAIT_CYCLES+2 cycles, with WAIT_CYCLES = CLK_HZ/1e6 × WAIT_US. Then comes a single-bit write of 1 to 0x41.
- R4: The sequencer then issues single-bit reads (`tp_write`=0, `tp_len`=1) of 0x42. It repeats the read until an acknowledge returns `tp_rdata[0]`=1.
- R5: After a successful poll, it reads 0x49 with `tp_len`=4 and then writes the returned 4-bit value to 0x44 with `tp_len`=4. In `tp_rdata` and `tp_wdata`, bit i is the field bit at base+i.
- R6: The script ends with single-bit writes of 0 to 0x41, of 0 to 0x40 and of 1 to 0x43, in that order. `done` is then high for exactly one cycle, and no further request follows.
- R7: When `done` pulses, `result` equals the code read from 0x49. It holds that value until the next accepted `start`.
- R8: If MAX_POLLS consecutive polls all return bit 0, there is no read of 0x49 and no write of 0x44. The release writes of R6 still run, `err` is high during the `done` cycle, and `result` is 0.
- R9: Each request's fields stay stable while `tp_req` is high until `tp_ack`. `tp_req` drops in the cycle after the acknowledge. Between consecutive requests, other than across the wait of R3, `tp_req` is low for exactly one cycle.
- R10: A `start` pulse while a sequence is running has no effect on the request stream or on the outcome.
- R11: A poll is judged only by `tp_rdata[0]`. Upper bits set to 1 in a poll response do not end polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration (sampled while idle) |
| done | output | 1 | One-cycle pulse at the end of the script |
| err | output | 1 | High with `done` when polling timed out |
| result | output | 4 | Calibration code latched from 0x49 |
| tp_req | output | 1 | Request to the test-port master, held until acknowledged |
| tp_write | output | 1 | 1 for a write request, 0 for a read |
| tp_addr | output | 8 | Base bit address of the access |
| tp_len | output | 3 | Number of bits accessed (1 to 4) |
| tp_wdata | output | 4 | Write data, bit i goes to base+i |
| tp_ack | input | 1 | One-cycle completion from the master |
| tp_rdata | input | 4 | Read data valid with `tp_ack` |

## Verification
The properties assume that the test-port master raises `tp_ack` only while `tp_req` is high and only for one cycle. Under that assumption, the drop of `tp_req` after an acknowledge and the absence of requests while idle are meaningful. The bench's master model keeps to this contract. It samples requests at the falling edge, waits a fixed latency, and then drives a single-cycle acknowledge with its read data. Its read responses follow a per-run plan of failing polls and a code value, so both the passing and the timed-out paths stay within the assumed handshake.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  localparam int ADDR_W    = 8;
  localparam int CODE_W    = 4;
  localparam int LEN_W     = 3;
  localparam int NUM_STEPS = 12;
  localparam int IDX_W     = $clog2(NUM_STEPS + 1);
  localparam int IDX_POLL    = 6;
  localparam int IDX_RELEASE = 9;

  typedef enum logic [2:0] {
    K_WRITE,
    K_POLL,
    K_READ_CODE,
    K_WRITE_CODE,
    K_DELAY
  } step_kind_e;

  typedef struct packed {
    step_kind_e        kind;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] data;
  } step_t;

  function automatic int wait_cycles(input int clk_hz, input int wait_us);
    return (clk_hz / 1_000_000) * wait_us;
  endfunction

  function automatic logic poll_passed(input logic [CODE_W-1:0] rd);
    return rd[0];
  endfunction

  function automatic step_t mk(input step_kind_e k, input int a, input int l, input int d);
    step_t s;
    s.kind = k;
    s.addr = ADDR_W'(a);
    s.len  = LEN_W'(l);
    s.data = CODE_W'(d);
    return s;
  endfunction

  function automatic step_t script_at(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      0:       return mk(K_WRITE,      'h43, 1, 0);
      1:       return mk(K_WRITE,      'h41, 1, 0);
      2:       return mk(K_WRITE,      'h40, 1, 0);
      3:       return mk(K_WRITE,      'h40, 1, 1);
      4:       return mk(K_DELAY,      'h00, 0, 0);
      5:       return mk(K_WRITE,      'h41, 1, 1);
      6:       return mk(K_POLL,       'h42, 1, 0);
      7:       return mk(K_READ_CODE,  'h49, 4, 0);
      8:       return mk(K_WRITE_CODE, 'h44, 4, 0);
      9:       return mk(K_WRITE,      'h41, 1, 0);
      10:      return mk(K_WRITE,      'h40, 1, 0);
      11:      return mk(K_WRITE,      'h43, 1, 1);
      default: return mk(K_DELAY,      'h00, 0, 0);
    endcase
  endfunction
endpackage

// File: rtl/tcal_script.sv
module tcal_script
  import tcal_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output step_t            entry
);
  assign entry = script_at(idx);
endmodule

// File: rtl/tcal_delay.sv
module tcal_delay #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= CW'(CYCLES);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/tcal_poll_guard.sv
module tcal_poll_guard #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fail,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (fail)   cnt <= cnt + CW'(1);
  end

  assign exhausted = (cnt == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/tcal_req_drv.sv
module tcal_req_drv
  import tcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  step_t             entry,
  input  logic [CODE_W-1:0] code,
  input  logic              ack,
  output logic              tp_req,
  output logic              tp_write,
  output logic [ADDR_W-1:0] tp_addr,
  output logic [LEN_W-1:0]  tp_len,
  output logic [CODE_W-1:0] tp_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_req   <= 1'b0;
      tp_write <= 1'b0;
      tp_addr  <= '0;
      tp_len   <= '0;
      tp_wdata <= '0;
    end else if (issue) begin
      tp_req   <= 1'b1;
      tp_write <= (entry.kind == K_WRITE) || (entry.kind == K_WRITE_CODE);
      tp_addr  <= entry.addr;
      tp_len   <= entry.len;
      tp_wdata <= (entry.kind == K_WRITE_CODE) ? code : entry.data;
    end else if (ack) begin
      tp_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/term_cal_seq.sv
module term_cal_seq
  import tcal_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int WAIT_US   = 1000,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] result,
  output logic              tp_req,
  output logic              tp_write,
  output logic [ADDR_W-1:0] tp_addr,
  output logic [LEN_W-1:0]  tp_len,
  output logic [CODE_W-1:0] tp_wdata,
  input  logic              tp_ack,
  input  logic [CODE_W-1:0] tp_rdata
);
  localparam int WAIT_CYCLES = wait_cycles(CLK_HZ, WAIT_US);

  typedef enum logic [2:0] {ST_IDLE, ST_STEP, ST_REQ, ST_WAIT, ST_DONE} state_e;

  state_e            state;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code_q;
  logic              to_flag;
  step_t             entry;

  // named internal events
  logic seq_busy, at_end, ev_start, ev_ack, ev_issue, ev_delay_load;
  logic ev_poll_pass, ev_poll_fail, ev_timeout, delay_expire, polls_exhausted;

  assign seq_busy      = (state != ST_IDLE);
  assign at_end        = (idx == IDX_W'(NUM_STEPS));
  assign ev_start      = (state == ST_IDLE) && start;
  assign ev_ack        = (state == ST_REQ) && tp_req && tp_ack;
  assign ev_issue      = (state == ST_STEP) && !at_end && (entry.kind != K_DELAY);
  assign ev_delay_load = (state == ST_STEP) && !at_end && (entry.kind == K_DELAY);
  assign ev_poll_pass  = ev_ack && (entry.kind == K_POLL) && poll_passed(tp_rdata);
  assign ev_poll_fail  = ev_ack && (entry.kind == K_POLL) && !poll_passed(tp_rdata);
  assign ev_timeout    = ev_poll_fail && polls_exhausted;

  tcal_script i_script (.idx(idx), .entry(entry));

  tcal_delay #(.CYCLES(WAIT_CYCLES)) i_delay (
    .clk(clk), .rst_n(rst_n), .load(ev_delay_load), .expire(delay_expire)
  );

  tcal_poll_guard #(.MAX_POLLS(MAX_POLLS)) i_guard (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .fail(ev_poll_fail),
    .exhausted(polls_exhausted)
  );

  tcal_req_drv i_req (
    .clk(clk), .rst_n(rst_n), .issue(ev_issue), .entry(entry), .code(code_q),
    .ack(ev_ack), .tp_req(tp_req), .tp_write(tp_write), .tp_addr(tp_addr),
    .tp_len(tp_len), .tp_wdata(tp_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      code_q  <= '0;
      to_flag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          idx     <= '0;
          code_q  <= '0;
          to_flag <= 1'b0;
          state   <= ST_STEP;
        end
        ST_STEP: begin
          if (at_end)                     state <= ST_DONE;
          else if (entry.kind == K_DELAY) state <= ST_WAIT;
          else                            state <= ST_REQ;
        end
        ST_REQ: if (ev_ack) begin
          state <= ST_STEP;
          if (ev_timeout) begin
            to_flag <= 1'b1;
            idx     <= IDX_W'(IDX_RELEASE);
          end else if (ev_poll_fail) begin
            idx <= idx;
          end else begin
            if (entry.kind == K_READ_CODE) code_q <= tp_rdata;
            idx <= idx + IDX_W'(1);
          end
        end
        ST_WAIT: if (delay_expire) begin
          idx   <= idx + IDX_W'(1);
          state <= ST_STEP;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done   = (state == ST_DONE);
  assign err    = done && to_flag;
  assign result = code_q;
endmodule

// File: rtl/tcal_checker.sv
module tcal_checker
  import tcal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              err,
  input logic [CODE_W-1:0] result,
  input logic              tp_req,
  input logic              tp_ack,
  input logic              tp_write,
  input logic [ADDR_W-1:0] tp_addr,
  input logic [LEN_W-1:0]  tp_len,
  input logic [CODE_W-1:0] tp_wdata,
  input logic              busy,
  input logic              timed_out
);
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tp_req && !tp_ack |=> tp_req && $stable({tp_write, tp_addr, tp_len, tp_wdata}));

  p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tp_req && tp_ack |=> !tp_req);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tp_req);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_no_trim_on_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out && tp_req |-> !(tp_write && tp_addr == ADDR_W'('h44)));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tp_req);
endmodule

bind term_cal_seq tcal_checker i_tcal_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err), .result(result),
  .tp_req(tp_req), .tp_ack(tp_ack), .tp_write(tp_write), .tp_addr(tp_addr),
  .tp_len(tp_len), .tp_wdata(tp_wdata), .busy(seq_busy), .timed_out(to_flag)
);

// File: tb/test_term_cal_seq.sv
module test_term_cal_seq;
  localparam int WAIT_US   = 1;
  localparam int MAX_POLLS = 5;
  localparam int WAIT_CYC  = 50 * WAIT_US;
  localparam int ACK_LAT   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done, err;
  logic [3:0] result;
  logic       tp_req, tp_write;
  logic [7:0] tp_addr;
  logic [2:0] tp_len;
  logic [3:0] tp_wdata;
  logic       tp_ack = 1'b0;
  logic [3:0] tp_rdata = 4'h0;

  always #10 clk = ~clk;

  term_cal_seq #(.CLK_HZ(50_000_000), .WAIT_US(WAIT_US), .MAX_POLLS(MAX_POLLS)) i_term_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err), .result(result),
    .tp_req(tp_req), .tp_write(tp_write), .tp_addr(tp_addr), .tp_len(tp_len),
    .tp_wdata(tp_wdata), .tp_ack(tp_ack), .tp_rdata(tp_rdata)
  );

  typedef struct { bit wr; int addr; int len; int wdata; int gap; string req; } exp_req_t;
  typedef struct { bit err; int result; } exp_end_t;

  exp_req_t req_q[$];
  exp_end_t end_q[$];
  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int resp_zeros = 0;
  int resp_code = 0;
  int polls_seen = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_req(input bit wr, input int addr, input int len, input int wdata,
                          input int gap, input string req);
    exp_req_t e;
    e.wr = wr; e.addr = addr; e.len = len; e.wdata = wdata; e.gap = gap; e.req = req;
    req_q.push_back(e);
  endtask

  // driver: builds the expected stream, then starts a run
  task automatic run_cal(input int zeros, input int code, input bit late_start);
    exp_end_t t;
    bit timeout;
    int npolls;
    timeout = (zeros >= MAX_POLLS);
    npolls  = timeout ? MAX_POLLS : zeros + 1;
    push_req(1, 'h43, 1, 0, -1, "R2");
    push_req(1, 'h41, 1, 0, 1, "R2");
    push_req(1, 'h40, 1, 0, 1, "R2");
    push_req(1, 'h40, 1, 1, 1, "R3");
    push_req(1, 'h41, 1, 1, WAIT_CYC + 2, "R3");
    for (int i = 0; i < npolls; i++) push_req(0, 'h42, 1, 0, 1, "R4");
    if (!timeout) begin
      push_req(0, 'h49, 4, 0, 1, "R5");
      push_req(1, 'h44, 4, code, 1, "R5");
    end
    push_req(1, 'h41, 1, 0, 1, "R6");
    push_req(1, 'h40, 1, 0, 1, "R6");
    push_req(1, 'h43, 1, 1, 1, "R6");
    t.err = timeout;
    t.result = timeout ? 0 : code;
    end_q.push_back(t);
    resp_zeros = zeros;
    resp_code  = code;
    polls_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (late_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;               // R10: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    wait (done_cnt == 1);
    done_cnt = 0;
    repeat (5) @(negedge clk);
    chk(req_q.size() == 0, "R6", "pending requests after done", req_q.size(), 0);
    chk(!tp_req, "R6", "tp_req after done", tp_req, 0);
    chk(result == 4'(t.result), "R7", "result held after done", result, t.result);
  endtask

  // monitor: test-port master model and request scoreboard
  initial begin
    int gap;
    exp_req_t e;
    gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || !tp_req) begin gap++; continue; end
      if (req_q.size() == 0) begin
        chk(0, "R6", "unexpected request addr", tp_addr, 0);
      end else begin
        e = req_q.pop_front();
        chk(tp_write == e.wr, e.req, "tp_write", tp_write, e.wr);
        chk(tp_addr == 8'(e.addr), e.req, "tp_addr", tp_addr, e.addr);
        chk(tp_len == 3'(e.len), e.req, "tp_len", tp_len, e.len);
        if (e.wr) chk(tp_wdata == 4'(e.wdata), e.req, "tp_wdata", tp_wdata, e.wdata);
        if (e.gap >= 0) chk(gap == e.gap, (e.gap > 1) ? "R3" : "R9", "idle cycles before request", gap, e.gap);
      end
      for (int k = 0; k < ACK_LAT; k++) begin
        @(negedge clk);
        chk(tp_req === 1'b1, "R9", "tp_req held before ack", tp_req, 1);
      end
      tp_ack = 1'b1;
      if (!tp_write && tp_addr == 8'h42) begin
        tp_rdata = (polls_seen < resp_zeros) ? 4'b1110 : 4'b0001;  // R11 junk upper bits
        polls_seen++;
      end else if (!tp_write && tp_addr == 8'h49) begin
        tp_rdata = 4'(resp_code);
      end else begin
        tp_rdata = 4'h0;
      end
      @(negedge clk);
      tp_ack = 1'b0;
      tp_rdata = 4'h0;
      chk(!tp_req, "R9", "tp_req after ack", tp_req, 0);
      gap = 1;
    end
  end

  // monitor: completion scoreboard
  initial begin
    bit prev_done;
    exp_end_t t;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (err && !done) chk(0, "R8", "err outside done", err, 0);
      if (prev_done && done) chk(0, "R6", "done wider than one cycle", done, 0);
      if (done) begin
        if (end_q.size() == 0) chk(0, "R6", "unexpected done", done, 0);
        else begin
          t = end_q.pop_front();
          chk(err == t.err, t.err ? "R8" : "R7", "err at done", err, t.err);
          chk(result == 4'(t.result), t.err ? "R8" : "R7", "result at done", result, t.result);
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tp_req, "R1", "tp_req in reset", tp_req, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(!err, "R1", "err in reset", err, 0);
    chk(result == 4'h0, "R1", "result in reset", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tp_req, "R1", "tp_req idle after reset", tp_req, 0);
    run_cal(0, 'hA, 0);                // first poll passes
    run_cal(3, 'h5, 0);                // R4/R11: three junk polls
    run_cal(MAX_POLLS - 1, 'hF, 1);    // last allowed poll passes, R10 late start
    run_cal(MAX_POLLS + 3, 'h9, 0);    // R8: timeout
    run_cal(1, 'h3, 0);                // recovers, err cleared
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule